// File: doc/BRIEF.md
# Serial Scan Adapter for an Asynchronous-Read RAM

This block puts a small word-organised RAM, one that reads combinationally and writes on the clock edge, into a one-bit serial scan chain. In normal operation the user port reads and writes whole words as if the adapter were absent. While the scan enable input is high, the RAM acts as a one-bit-wide FIFO. On every clock, one stored bit is presented on the serial output. On the next edge the incoming serial bit is written into that same bit position. The contents can therefore be read out and replaced in a single pass.

An internal position counter holds a word index and a bit index, with the bit index the least significant. It walks the RAM in a fixed order: word 0 bit 0, word 0 bit 1, and so on up to the last bit of the last word, then it wraps. The counter is held at zero whenever scan is not enabled, so every scan session starts at the same place. A complete pass over a RAM of DEPTH words by WIDTH bits takes DEPTH×WIDTH cycles. The counter value is brought out so that neighbouring RAMs instrumented the same way can follow the same sequence.

Top module: `scan_ram_adapter`

## Requirements
- R1: While rst_n is low at a clock edge, the position counter (scan_word, scan_bit) becomes 0, whatever scan_en is.
- R2: With scan_en low, a clock edge with usr_we high stores usr_wdata at word usr_addr, and usr_rdata shows, without a clock, the word stored at usr_addr.
- R3: With scan_en high, scan_out equals bit scan_bit of word scan_word, and usr_rdata shows that whole word. With scan_en low, scan_out is 0.
- R4: Each clock edge with scan_en high writes scan_in into bit scan_bit of word scan_word. All other bits of that word and all other words keep their values.
- R5: With scan_en high, usr_we, usr_addr and usr_wdata have no effect on the RAM contents.
- R6: The counter is 0 on the first cycle of every scan session, including a session that follows one stopped part-way.
- R7: Each clock edge with scan_en high advances the counter by one bit position, with the bit index least significant (the bit index runs 0 to WIDTH-1, then the word index steps). After word DEPTH-1, bit WIDTH-1, it wraps to word 0, bit 0.
- R8: Shifting in, over a full session of DEPTH×WIDTH cycles, the bit stream captured on scan_out in an earlier full session restores every word to the value it held before that earlier session. Feeding scan_out straight back to scan_in leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the position counter |
| usr_addr | input | AW = clog2(DEPTH) | User word address |
| usr_wdata | input | WIDTH | User write word |
| usr_we | input | 1 | User write strobe |
| usr_rdata | output | WIDTH | Word at the selected address (user or scan) |
| scan_en | input | 1 | Scan session active |
| scan_in | input | 1 | Serial bit entering the RAM |
| scan_out | output | 1 | Serial bit leaving the RAM |
| scan_word | output | AW | Word index of the position counter |
| scan_bit | output | BW = clog2(WIDTH), minimum 1 | Bit index of the position counter |

## Verification
A position counter that is off by one, fails to clear between sessions or wraps early shows on scan_word and scan_bit on the very next cycle. From then on, every bit on scan_out comes from the wrong place. A faulty merge of the serial bit into the stored word, or a user write that leaks through during scan, corrupts a stored word. That corruption is not visible on the clock edge that causes it. It appears on usr_rdata the next time the word is addressed, or on scan_out when the counter returns to that position. The reference model follows the stored contents cycle by cycle, so such an error is caught at that first later visit.

// File: rtl/scan_ram_pkg.sv
// Shared definitions for the scan RAM adapter.
// Assumes nothing beyond a standard SystemVerilog compile order (package first).
package scan_ram_pkg;

    // Which side owns the RAM address and write port in the current cycle.
    typedef enum logic {
        SRC_USER = 1'b0,
        SRC_SCAN = 1'b1
    } port_src_e;

    // Linear position of a (word, bit) pair in the serial order.
    function automatic int unsigned lin_pos(input int unsigned word_idx,
                                            input int unsigned bit_idx,
                                            input int unsigned width);
        return word_idx * width + bit_idx;
    endfunction

endpackage

// File: rtl/scan_addr_gen.sv
// Scan position counter: a word index with a bit index below it.
// It steps one bit per cycle while scan_en is high and wraps after the last bit
// of the last word. It is held at zero whenever scan_en is low or reset is active.
// Assumes WIDTH >= 1 and DEPTH >= 2. The widths come from the parent.
module scan_addr_gen #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4,
    parameter int AW    = 4,
    parameter int BW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    output logic [AW-1:0] word_q,
    output logic [BW-1:0] bit_q,
    output logic          last_pos
);
    import scan_ram_pkg::*;

    logic bit_wrap;
    logic word_wrap;

    assign bit_wrap  = (bit_q == BW'(WIDTH - 1));
    assign word_wrap = (word_q == AW'(DEPTH - 1));
    assign last_pos  = bit_wrap && word_wrap;

    // Bit index: counts 0..WIDTH-1 during scan and clears otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en || bit_wrap) begin
            bit_q <= '0;
        end else begin
            bit_q <= bit_q + BW'(1);
        end
    end

    // Word index: steps when the bit index wraps and clears outside scan.
    always_ff @(posedge clk) begin
        if (!rst_n || !scan_en) begin
            word_q <= '0;
        end else if (bit_wrap) begin
            word_q <= word_wrap ? '0 : word_q + AW'(1);
        end
    end

    // Linear position, used only by the assertions below.
    int unsigned pos_now;
    assign pos_now = lin_pos(int'(word_q), int'(bit_q), WIDTH);

    assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (word_q == '0 && bit_q == '0))
        else $error("position counter not cleared after idle cycle");

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !last_pos) |=> (pos_now == $past(pos_now) + 1))
        else $error("position counter did not advance by one bit");

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && last_pos) |=> (pos_now == 0))
        else $error("position counter did not wrap to zero");

endmodule

// File: rtl/scan_port_mux.sv
// Port steering between the user side and the scan side.
// During scan, the address comes from the position counter, writes are forced
// on, and the write word is the stored word with one bit replaced by scan_in.
// The serial output is the selected bit of the word read this cycle.
// Assumes the RAM read is combinational, so rd_word is valid within the cycle.
module scan_port_mux #(
    parameter int WIDTH = 4,
    parameter int AW    = 4,
    parameter int BW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             scan_in,
    input  logic [AW-1:0]    scan_word,
    input  logic [BW-1:0]    scan_bit,
    input  logic [AW-1:0]    usr_addr,
    input  logic [WIDTH-1:0] usr_wdata,
    input  logic             usr_we,
    input  logic [WIDTH-1:0] rd_word,
    output logic [AW-1:0]    ram_addr,
    output logic [WIDTH-1:0] ram_wdata,
    output logic             ram_we,
    output logic             scan_out
);
    import scan_ram_pkg::*;

    port_src_e        src;
    logic [WIDTH-1:0] bit_mask;
    logic [WIDTH-1:0] merged;

    // Owner of the RAM port this cycle.
    assign src = scan_en ? SRC_SCAN : SRC_USER;

    // One-hot mask of the bit under the scan pointer.
    assign bit_mask = WIDTH'(1) << scan_bit;

    // Stored word with the pointed bit replaced by the serial input.
    assign merged = (rd_word & ~bit_mask) | (scan_in ? bit_mask : '0);

    // Address, data and write-strobe selection.
    always_comb begin
        if (src == SRC_SCAN) begin
            ram_addr  = scan_word;
            ram_wdata = merged;
            ram_we    = 1'b1;
        end else begin
            ram_addr  = usr_addr;
            ram_wdata = usr_wdata;
            ram_we    = usr_we;
        end
    end

    // Serial output: the pointed bit during scan, quiet otherwise.
    assign scan_out = (src == SRC_SCAN) && ((rd_word & bit_mask) != '0);

    assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> ($countones(ram_wdata ^ rd_word) <= 1))
        else $error("scan write changes more than one bit");

    assert_user_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (ram_addr == scan_word && ram_we))
        else $error("user port reached the RAM during scan");

endmodule

// File: rtl/ram_async_rd.sv
// Word RAM with a combinational read and a write on the clock edge.
// Contents are not reset. Addresses at or above DEPTH are not written.
module ram_async_rd #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             we,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             in_range;

    assign in_range = (int'(addr) < DEPTH);

    // Storage write.
    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[addr] <= wdata;
        end
    end

    // Combinational read; out-of-range addresses read as zero.
    assign rdata = in_range ? mem[addr] : '0;

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> (mem[$past(addr)] === $past(wdata)))
        else $error("written word not found in storage");

endmodule

// File: rtl/scan_ram_adapter.sv
// Top level: a RAM wrapped so it can sit in a one-bit serial scan chain.
// Normal mode passes the user port through. Scan mode streams bit by bit,
// word 0 bit 0 first, and writes each incoming bit back into the position it
// replaces. The counter outputs let other RAMs follow the same sequence.
// Assumes scan_in is held stable around the clock edge like any synchronous input.
module scan_ram_adapter #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    usr_addr,
    input  logic [WIDTH-1:0] usr_wdata,
    input  logic             usr_we,
    output logic [WIDTH-1:0] usr_rdata,
    input  logic             scan_en,
    input  logic             scan_in,
    output logic             scan_out,
    output logic [AW-1:0]    scan_word,
    output logic [BW-1:0]    scan_bit
);
    logic [AW-1:0]    ram_addr;
    logic [WIDTH-1:0] ram_wdata;
    logic             ram_we;
    logic [WIDTH-1:0] rd_word;
    logic             last_pos;

    // Position counter.
    scan_addr_gen #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .BW(BW)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en  (scan_en),
        .word_q   (scan_word),
        .bit_q    (scan_bit),
        .last_pos (last_pos)
    );

    // Port steering and bit serialisation.
    scan_port_mux #(.WIDTH(WIDTH), .AW(AW), .BW(BW)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_en   (scan_en),
        .scan_in   (scan_in),
        .scan_word (scan_word),
        .scan_bit  (scan_bit),
        .usr_addr  (usr_addr),
        .usr_wdata (usr_wdata),
        .usr_we    (usr_we),
        .rd_word   (rd_word),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .scan_out  (scan_out)
    );

    // Storage.
    ram_async_rd #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .we    (ram_we),
        .rdata (rd_word)
    );

    // Read data follows the selected address.
    assign usr_rdata = rd_word;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (scan_word == '0 && scan_bit == '0))
        else $error("counter not zero after reset");

    assert_out_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> !scan_out)
        else $error("serial output active outside scan");

endmodule

// File: tb/sim_scan_ram_adapter.sv
// Bench: a behavioural model of the RAM contents and scan position,
// compared with the ports on every clock.
module sim_scan_ram_adapter;
    localparam int D  = 16;
    localparam int W  = 4;
    localparam int AW = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [W-1:0]  usr_wdata = '0;
    logic          usr_we = 1'b0;
    logic [W-1:0]  usr_rdata;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [AW-1:0] scan_word;
    logic [BW-1:0] scan_bit;

    int checks = 0;
    int errors = 0;
    int mem_m [D];
    int orig [D];
    int cw = 0;
    int cb = 0;
    bit init_done = 0;
    bit cap [$];
    int lfsr = 32'h1d;

    always #2 clk = ~clk;

    scan_ram_adapter #(.DEPTH(D), .WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
        .usr_we(usr_we), .usr_rdata(usr_rdata), .scan_en(scan_en),
        .scan_in(scan_in), .scan_out(scan_out), .scan_word(scan_word),
        .scan_bit(scan_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, compare outputs with the model, update the model at the edge.
    task automatic tick(input bit se, input bit si, input bit we, input int a, input int wd);
        int sel;
        int exp_out;
        scan_en = se; scan_in = si; usr_we = we;
        usr_addr = AW'(a); usr_wdata = W'(wd);
        #1;
        check(int'(scan_word) == cw, "R7 counter word", int'(scan_word), cw);
        check(int'(scan_bit) == cb, "R7 counter bit", int'(scan_bit), cb);
        if (init_done) begin
            sel = se ? cw : a;
            check(int'(usr_rdata) == mem_m[sel], se ? "R3 scan word read" : "R2 user read",
                  int'(usr_rdata), mem_m[sel]);
            exp_out = se ? ((mem_m[cw] >> cb) & 1) : 0;
            check(int'(scan_out) == exp_out, "R3 serial output", int'(scan_out), exp_out);
        end
        if (se) cap.push_back(bit'((mem_m[cw] >> cb) & 1));
        @(posedge clk);
        if (!rst_n) begin
            cw = 0; cb = 0;
        end else if (se) begin
            mem_m[cw] = (mem_m[cw] & ~(1 << cb)) | (int'(si) << cb);
            if (cb == W - 1) begin
                cb = 0;
                cw = (cw == D - 1) ? 0 : cw + 1;
            end else begin
                cb = cb + 1;
            end
        end else begin
            if (we) mem_m[a] = wd;
            cw = 0; cb = 0;
        end
        #1;
    endtask

    function automatic int next_rand();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        return lfsr;
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with scan_en high keeps the counter at zero.
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 1'b0, 0, 0);
        check(scan_word == '0 && scan_bit == '0, "R1 reset counter",
              int'({scan_word, scan_bit}), 0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0, 0, 0);

        // R2: fill every word through the user port, then read back.
        for (int i = 0; i < D; i++) tick(1'b0, 1'b0, 1'b1, i, (i * 5 + 3) & 15);
        init_done = 1;
        for (int i = D - 1; i >= 0; i--) tick(1'b0, 1'b0, 1'b0, i, 0);
        tick(1'b0, 1'b0, 1'b1, 7, 4'hA);
        tick(1'b0, 1'b0, 1'b0, 7, 0);
        check(usr_rdata == 4'hA, "R2 write then read", int'(usr_rdata), 10);

        // R8: loop-back session leaves contents unchanged.
        for (int i = 0; i < D; i++) orig[i] = mem_m[i];
        for (int i = 0; i < D * W; i++) tick(1'b1, bit'((mem_m[cw] >> cb) & 1), 1'b0, 0, 0);
        tick(1'b0, 1'b0, 1'b0, 0, 0);
        for (int i = 0; i < D; i++) begin
            tick(1'b0, 1'b0, 1'b0, i, 0);
            check(int'(usr_rdata) == orig[i], "R8 loop-back keeps word", int'(usr_rdata), orig[i]);
        end

        // R6: stop a session part-way, then restart from zero.
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, 1'b0, 0, 0);
        tick(1'b0, 1'b0, 1'b0, 1, 0);
        scan_en = 1'b1; #1;
        check(scan_word == '0 && scan_bit == '0, "R6 restart at zero",
              int'({scan_word, scan_bit}), 0);
        check(usr_rdata == W'(mem_m[0]), "R4 partial session bits", int'(usr_rdata), mem_m[0]);

        // R5 and R4: full session of random bits while the user port toggles.
        for (int i = 0; i < D; i++) orig[i] = mem_m[i];
        cap.delete();
        for (int i = 0; i < D * W; i++) begin
            void'(next_rand());
            tick(1'b1, bit'(lfsr & 1), 1'b1, (lfsr >> 3) & 15, (lfsr >> 7) & 15);
        end
        tick(1'b0, 1'b0, 1'b0, 0, 0);

        // R8: shift the captured stream back in over a full session.
        begin
            bit stream [$];
            stream = cap;
            for (int i = 0; i < D * W; i++) tick(1'b1, stream[i], 1'b0, 0, 0);
        end
        tick(1'b0, 1'b0, 1'b0, 0, 0);
        for (int i = 0; i < D; i++) begin
            tick(1'b0, 1'b0, 1'b0, i, 0);
            check(int'(usr_rdata) == orig[i], "R8 captured stream restores word",
                  int'(usr_rdata), orig[i]);
        end

        // R7: a session running past the wrap point.
        for (int i = 0; i < D * W + 6; i++) begin
            void'(next_rand());
            tick(1'b1, bit'(lfsr & 1), 1'b0, 0, 0);
        end
        tick(1'b0, 1'b0, 1'b0, 3, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule